// File: doc/BRIEF.md
# Graphic LCD Segment Driver Host Port

This block is the 8-bit parallel host-side front end of a 64-column graphic LCD segment driver. A microcontroller reaches it through an enable strobe, a data/command select, a read/write select, three chip selects and an active-low reset. The bidirectional data bus appears as a separate input, output and output enable. The block samples the strobe with its own clock and decodes the access on each falling edge of E. It holds the page register, the column counter, the display on/off flag and the start-line register. It writes and reads a 512x8 display RAM through a synchronous port. Display data reads go through an output register, so the first read after an address change returns stale data.

The start line and the on/off flag are brought out for the scan engine. After every accepted access a busy flag is raised for a fixed number of clock cycles. Accesses that arrive while busy is high are dropped. While reset is held low only status reads are served.

Top module: `gldc_host_if`

## Requirements
- R1: When the chip is not selected, an access changes no state and moves no counter. The chip is selected only when cs1_n=0, cs2_n=0 and cs3=1.
- R2: The pair {rs, rw} selects the access: 00 command write, 01 status read, 10 display data write, 11 display data read. A byte written with rs=1 is never decoded as a command.
- R3: Command 0011111D sets the display flag, with D=1 meaning on. The flag is visible on disp_on_o.
- R4: Command 01CCCCCC loads the column (0-63) and command 10111PPP loads the page (0-7). The RAM address of a data access is page*64+column.
- R5: Command 11LLLLLL loads the start line (0-63), which is visible on start_line_o.
- R6: A status read returns bit 7 = busy, bit 5 = display off (1 means off) and bit 4 = reset held. All other bits are 0.
- R7: A display data read returns the output register, and the output register is then reloaded from RAM at the current address. Reset clears the output register to 0, so the first read after an address change returns stale data.
- R8: The column increments after every accepted data write and data read, wrapping from 63 to 0. The page never changes except by command.
- R9: While rst_n is low, the display is off, the start line, page, column and output register are 0, and every access other than a status read is ignored (including RAM writes).
- R10: An accepted command write, data write or data read raises busy_o for exactly BUSY_CYC clock cycles (default 2). Any access that falls while busy_o is high is ignored.
- R11: dbus_oe_o is high only during a selected read with E high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| e_i | input | 1 | Host enable strobe; writes take effect on its falling edge |
| rs_i | input | 1 | 1 = display data, 0 = command/status |
| rw_i | input | 1 | 1 = read, 0 = write |
| cs1_n_i | input | 1 | Chip select, active low |
| cs2_n_i | input | 1 | Chip select, active low |
| cs3_i | input | 1 | Chip select, active high |
| dbus_i | input | 8 | Data bus from host |
| dbus_o | output | 8 | Data bus to host |
| dbus_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Internal operation in progress |
| disp_on_o | output | 1 | Display enabled flag for the scan engine |
| start_line_o | output | 6 | RAM line shown at the top of the panel |

## Verification
The bench reads back data after the column wraps from 63 to 0. A counter that saturated or carried into the page would return data from the wrong location. It changes the page and column between read bursts and checks that each first read returns the previous burst's leftover byte. A design without the output-register pipeline would return fresh data too early. It issues a second command while busy is still high and checks that the command is lost and that busy drops after exactly two cycles. It also attempts a display write under reset and later reads that RAM location to confirm the old contents survived. Accesses with the chip deselected must leave the flags, the column and the bus enable untouched.

// File: rtl/gldc_pkg.sv
package gldc_pkg;

   // Access kind, indexed by {rs, rw}
   typedef enum logic [1:0] {
      ACC_CMD    = 2'b00,
      ACC_STATUS = 2'b01,
      ACC_WDATA  = 2'b10,
      ACC_RDATA  = 2'b11
   } acc_e;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_DISP,
      OP_COL,
      OP_PAGE,
      OP_START
   } op_e;

   localparam int STAT_BUSY_BIT = 7;
   localparam int STAT_OFF_BIT  = 5;
   localparam int STAT_RST_BIT  = 4;

   function automatic op_e decode_op(input logic [7:0] b);
      op_e r;
      if (b[7:1] == 7'b0011111)      r = OP_DISP;
      else if (b[7:6] == 2'b01)      r = OP_COL;
      else if (b[7:3] == 5'b10111)   r = OP_PAGE;
      else if (b[7:6] == 2'b11)      r = OP_START;
      else                           r = OP_NONE;
      return r;
   endfunction

   function automatic logic [7:0] make_status(input logic busy,
                                              input logic off,
                                              input logic in_rst);
      logic [7:0] s;
      s = '0;
      s[STAT_BUSY_BIT] = busy;
      s[STAT_OFF_BIT]  = off;
      s[STAT_RST_BIT]  = in_rst;
      return s;
   endfunction

endpackage

// File: rtl/gldc_bus_if.sv
module gldc_bus_if
   import gldc_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              e_i,
   input  logic              rs_i,
   input  logic              rw_i,
   input  logic              cs1_n_i,
   input  logic              cs2_n_i,
   input  logic              cs3_i,
   input  logic [DATA_W-1:0] din_i,
   input  logic              busy_i,
   output logic              cmd_wr_o,
   output logic              dat_wr_o,
   output logic              dat_rd_o,
   output op_e               op_o,
   output logic [DATA_W-1:0] arg_o,
   output logic              bus_oe_o
);

   logic e_q;
   logic sel;
   logic fall;
   logic take;
   acc_e acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) e_q <= 1'b0;
      else        e_q <= e_i;
   end

   assign sel  = ~cs1_n_i & ~cs2_n_i & cs3_i;
   assign acc  = acc_e'({rs_i, rw_i});
   assign fall = e_q & ~e_i;
   assign take = fall & sel & ~busy_i;

   assign cmd_wr_o = take & (acc == ACC_CMD);
   assign dat_wr_o = take & (acc == ACC_WDATA);
   assign dat_rd_o = take & (acc == ACC_RDATA);

   assign op_o     = decode_op(din_i);
   assign arg_o    = din_i;
   assign bus_oe_o = sel & rw_i & e_i;

endmodule

// File: rtl/gldc_ctrl_regs.sv
module gldc_ctrl_regs
   import gldc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int COL_W    = 6,
   parameter int PAGE_W   = 3,
   parameter int BUSY_CYC = 2,
   localparam int ADDR_W  = PAGE_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr_i,
   input  logic              dat_wr_i,
   input  logic              dat_rd_i,
   input  op_e               op_i,
   input  logic [DATA_W-1:0] arg_i,
   input  logic [DATA_W-1:0] ram_rdata_i,
   output logic              ram_we_o,
   output logic              ram_re_o,
   output logic [ADDR_W-1:0] ram_addr_o,
   output logic [DATA_W-1:0] ram_wdata_o,
   output logic              busy_o,
   output logic              disp_on_o,
   output logic [COL_W-1:0]  start_o,
   output logic [DATA_W-1:0] outreg_o
);

   logic [PAGE_W-1:0] page_q;
   logic [COL_W-1:0]  col_q;
   logic [COL_W-1:0]  start_q;
   logic              disp_q;
   logic              rd_pend_q;
   logic [DATA_W-1:0] outreg_q;
   logic              access;

   assign access = cmd_wr_i | dat_wr_i | dat_rd_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         page_q  <= '0;
         col_q   <= '0;
         start_q <= '0;
         disp_q  <= 1'b0;
      end else begin
         if (cmd_wr_i) begin
            case (op_i)
               OP_DISP:  disp_q  <= arg_i[0];
               OP_COL:   col_q   <= arg_i[COL_W-1:0];
               OP_PAGE:  page_q  <= arg_i[PAGE_W-1:0];
               OP_START: start_q <= arg_i[COL_W-1:0];
               default:  ;
            endcase
         end
         if (dat_wr_i | dat_rd_i) col_q <= col_q + COL_W'(1);
      end
   end

   // Read pipeline: RAM answers one cycle after the strobe
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_pend_q <= 1'b0;
         outreg_q  <= '0;
      end else begin
         rd_pend_q <= dat_rd_i;
         if (rd_pend_q) outreg_q <= ram_rdata_i;
      end
   end

   generate
      if (BUSY_CYC == 1) begin : g_busy_flag
         logic busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) busy_q <= 1'b0;
            else        busy_q <= access;
         end
         assign busy_o = busy_q;
      end else begin : g_busy_cnt
         localparam int CNT_W = $clog2(BUSY_CYC + 1);
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)             cnt_q <= '0;
            else if (access)        cnt_q <= CNT_W'(BUSY_CYC);
            else if (cnt_q != '0)   cnt_q <= cnt_q - CNT_W'(1);
         end
         assign busy_o = (cnt_q != '0);
      end
   endgenerate

   assign ram_we_o    = dat_wr_i;
   assign ram_re_o    = dat_rd_i;
   assign ram_addr_o  = {page_q, col_q};
   assign ram_wdata_o = arg_i;
   assign disp_on_o   = disp_q;
   assign start_o     = start_q;
   assign outreg_o    = outreg_q;

endmodule

// File: rtl/gldc_dram.sv
module gldc_dram #(
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 9,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we_i,
   input  logic              re_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o
);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [DATA_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (we_i) mem[addr_i] <= wdata_i;
      if (re_i) rdata_q <= mem[addr_i];
   end

   assign rdata_o = rdata_q;

endmodule

// File: rtl/gldc_host_if.sv
module gldc_host_if
   import gldc_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int COL_W    = 6,
   parameter int PAGE_W   = 3,
   parameter int BUSY_CYC = 2,
   localparam int ADDR_W  = PAGE_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              e_i,
   input  logic              rs_i,
   input  logic              rw_i,
   input  logic              cs1_n_i,
   input  logic              cs2_n_i,
   input  logic              cs3_i,
   input  logic [DATA_W-1:0] dbus_i,
   output logic [DATA_W-1:0] dbus_o,
   output logic              dbus_oe_o,
   output logic              busy_o,
   output logic              disp_on_o,
   output logic [COL_W-1:0]  start_line_o
);

   generate
      if (DATA_W != 8) begin : g_bad_data_w
         $error("gldc_host_if: command encodings need an 8-bit bus");
      end
      if (COL_W != DATA_W - 2) begin : g_bad_col_w
         $error("gldc_host_if: column field must fill the command argument");
      end
      if (PAGE_W < 1 || PAGE_W > 3) begin : g_bad_page_w
         $error("gldc_host_if: page field is at most 3 bits");
      end
      if (BUSY_CYC < 1 || BUSY_CYC > 3) begin : g_bad_busy
         $error("gldc_host_if: busy window must be 1 to 3 cycles");
      end
   endgenerate

   logic              cmd_wr, dat_wr, dat_rd;
   op_e               op;
   logic [DATA_W-1:0] arg;
   logic              ram_we, ram_re;
   logic [ADDR_W-1:0] ram_addr;
   logic [DATA_W-1:0] ram_wdata, ram_rdata;
   logic [DATA_W-1:0] outreg;
   logic              busy;
   logic              disp_on;
   logic [DATA_W-1:0] status;

   gldc_bus_if #(.DATA_W(DATA_W)) u_bus (
      .clk      (clk),
      .rst_n    (rst_n),
      .e_i      (e_i),
      .rs_i     (rs_i),
      .rw_i     (rw_i),
      .cs1_n_i  (cs1_n_i),
      .cs2_n_i  (cs2_n_i),
      .cs3_i    (cs3_i),
      .din_i    (dbus_i),
      .busy_i   (busy),
      .cmd_wr_o (cmd_wr),
      .dat_wr_o (dat_wr),
      .dat_rd_o (dat_rd),
      .op_o     (op),
      .arg_o    (arg),
      .bus_oe_o (dbus_oe_o)
   );

   gldc_ctrl_regs #(
      .DATA_W   (DATA_W),
      .COL_W    (COL_W),
      .PAGE_W   (PAGE_W),
      .BUSY_CYC (BUSY_CYC)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .cmd_wr_i    (cmd_wr),
      .dat_wr_i    (dat_wr),
      .dat_rd_i    (dat_rd),
      .op_i        (op),
      .arg_i       (arg),
      .ram_rdata_i (ram_rdata),
      .ram_we_o    (ram_we),
      .ram_re_o    (ram_re),
      .ram_addr_o  (ram_addr),
      .ram_wdata_o (ram_wdata),
      .busy_o      (busy),
      .disp_on_o   (disp_on),
      .start_o     (start_line_o),
      .outreg_o    (outreg)
   );

   gldc_dram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
      .clk     (clk),
      .we_i    (ram_we),
      .re_i    (ram_re),
      .addr_i  (ram_addr),
      .wdata_i (ram_wdata),
      .rdata_o (ram_rdata)
   );

   assign status    = make_status(busy, ~disp_on, ~rst_n);
   assign dbus_o    = rs_i ? outreg : status;
   assign busy_o    = busy;
   assign disp_on_o = disp_on;

endmodule

// File: rtl/gldc_host_if_chk.sv
module gldc_host_if_chk #(
   parameter int BUSY_CYC = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       e_i,
   input logic       rs_i,
   input logic       rw_i,
   input logic       cs1_n_i,
   input logic       cs2_n_i,
   input logic       cs3_i,
   input logic [7:0] dbus_i,
   input logic [7:0] dbus_o,
   input logic       dbus_oe_o,
   input logic       busy_o,
   input logic       disp_on_o,
   input logic [5:0] start_line_o
);

   logic       e_seen;
   logic [2:0] busy_run;
   logic       sel_c;
   logic       fall_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_seen   <= 1'b0;
         busy_run <= '0;
      end else begin
         e_seen   <= e_i;
         busy_run <= busy_o ? busy_run + 3'd1 : 3'd0;
      end
   end

   assign sel_c  = ~cs1_n_i & ~cs2_n_i & cs3_i;
   assign fall_c = e_seen & ~e_i;

   p_unsel_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && !sel_c) |=> ($stable(disp_on_o) && $stable(start_line_o)));

   p_disp_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && sel_c && !busy_o && !rs_i && !rw_i && dbus_i[7:1] == 7'b0011111)
      |=> (disp_on_o == $past(dbus_i[0])));

   p_start_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && sel_c && !busy_o && !rs_i && !rw_i && dbus_i[7:6] == 2'b11)
      |=> (start_line_o == $past(dbus_i[5:0])));

   p_status_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dbus_oe_o && !rs_i) |-> (dbus_o[6] == 1'b0 && dbus_o[3:0] == 4'd0 &&
                                dbus_o[7] == busy_o && dbus_o[5] == !disp_on_o));

   p_busy_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && sel_c && !busy_o && !(!rs_i && rw_i)) |=> busy_o);

   p_busy_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy_run <= 3'(BUSY_CYC));

   p_busy_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fall_c && sel_c && busy_o) |=> ($stable(disp_on_o) && $stable(start_line_o)));

   p_oe_read_r11: assert property (@(posedge clk) disable iff (!rst_n)
      dbus_oe_o |-> (e_i && rw_i && sel_c));

   // R9: state held cleared while reset is low
   always @(posedge clk) begin
      if (!rst_n) begin
         p_reset_state_r9: assert (!disp_on_o && start_line_o == 6'd0 && !busy_o);
         if (dbus_oe_o && !rs_i)
            p_reset_flag_r9: assert (dbus_o[4] == 1'b1);
      end
   end

endmodule

bind gldc_host_if gldc_host_if_chk #(.BUSY_CYC(BUSY_CYC)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .e_i          (e_i),
   .rs_i         (rs_i),
   .rw_i         (rw_i),
   .cs1_n_i      (cs1_n_i),
   .cs2_n_i      (cs2_n_i),
   .cs3_i        (cs3_i),
   .dbus_i       (dbus_i),
   .dbus_o       (dbus_o),
   .dbus_oe_o    (dbus_oe_o),
   .busy_o       (busy_o),
   .disp_on_o    (disp_on_o),
   .start_line_o (start_line_o)
);

// File: tb/gldc_host_if_tb_top.sv
module gldc_host_if_tb_top;

   localparam int CLK_P = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b1;
   logic       e = 1'b0, rs = 1'b0, rw = 1'b0;
   logic       cs1_n = 1'b1, cs2_n = 1'b1, cs3 = 1'b0;
   logic [7:0] din = 8'h00;
   logic [7:0] dout;
   logic       oe, busy, disp_on;
   logic [5:0] start_line;

   int vectors = 0;
   int fails   = 0;

   // reference model state
   logic [7:0] m_mem [512];
   logic [2:0] m_page = 3'd0;
   logic [5:0] m_col  = 6'd0;
   logic [7:0] m_out  = 8'h00;

   logic [7:0] exp_q [$];
   string      tag_q [$];
   logic       sample_req = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   gldc_host_if dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .e_i          (e),
      .rs_i         (rs),
      .rw_i         (rw),
      .cs1_n_i      (cs1_n),
      .cs2_n_i      (cs2_n),
      .cs3_i        (cs3),
      .dbus_i       (din),
      .dbus_o       (dout),
      .dbus_oe_o    (oe),
      .busy_o       (busy),
      .disp_on_o    (disp_on),
      .start_line_o (start_line)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
   endtask

   // scoreboard monitor: pops one expected bus value per sample request
   always begin
      @(negedge clk);
      #1;
      if (sample_req) begin
         if (exp_q.size() == 0) begin
            chk(8'hxx, 8'h00, "monitor queue empty");
         end else begin
            logic [7:0] ex;
            string      tg;
            ex = exp_q.pop_front();
            tg = tag_q.pop_front();
            chk({7'd0, oe}, 8'd1, {tg, " oe"});
            chk(dout, ex, tg);
         end
      end
   end

   task automatic access(input logic rs_v, input logic rw_v, input logic [7:0] d,
                         input bit selv, input bit rd_chk, input logic [7:0] exp,
                         input string tag);
      @(negedge clk);
      rs = rs_v; rw = rw_v; din = d;
      cs1_n = !selv; cs2_n = !selv; cs3 = selv;
      e = 1'b1;
      @(negedge clk);
      if (rd_chk) begin
         exp_q.push_back(exp);
         tag_q.push_back(tag);
         sample_req = 1'b1;
      end
      @(negedge clk);
      sample_req = 1'b0;
      e = 1'b0;
      repeat (5) @(negedge clk);
      cs1_n = 1'b1; cs2_n = 1'b1; cs3 = 1'b0;
   endtask

   task automatic cmd(input logic [7:0] b);
      access(1'b0, 1'b0, b, 1'b1, 1'b0, 8'h00, "");
      if (b[7:6] == 2'b01)      m_col  = b[5:0];
      else if (b[7:3] == 5'b10111) m_page = b[2:0];
   endtask

   task automatic wr(input logic [7:0] b);
      access(1'b1, 1'b0, b, 1'b1, 1'b0, 8'h00, "");
      m_mem[{m_page, m_col}] = b;
      m_col = m_col + 6'd1;
   endtask

   task automatic rd(input string tag);
      access(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, m_out, tag);
      m_out = m_mem[{m_page, m_col}];
      m_col = m_col + 6'd1;
   endtask

   task automatic status(input logic [7:0] exp, input string tag);
      access(1'b0, 1'b1, 8'h00, 1'b1, 1'b1, exp, tag);
   endtask

   initial begin
      #(CLK_P * 200000);
      fails++;
      vectors++;
      $display("FAIL watchdog: actual running expected done");
      summary();
      $finish;
   end

   initial begin
      #2 rst_n = 1'b0;
      repeat (3) @(negedge clk);
      chk({7'd0, disp_on}, 8'd0, "R9 display off in reset");
      chk({2'd0, start_line}, 8'd0, "R9 start line zero in reset");
      chk({7'd0, oe}, 8'd0, "R11 bus idle");
      status(8'h30, "R9 status read served in reset");
      rst_n = 1'b1;
      status(8'h20, "R6 status after reset");

      cmd(8'h3F);
      chk({7'd0, disp_on}, 8'd1, "R3 display on");
      status(8'h00, "R6 status display on");
      cmd(8'h3E);
      chk({7'd0, disp_on}, 8'd0, "R3 display off");
      cmd(8'hC0 | 8'd45);
      chk({2'd0, start_line}, 8'd45, "R5 start line 45");

      // R1: deselected accesses
      access(1'b0, 1'b0, 8'h3F, 1'b0, 1'b0, 8'h00, "");
      chk({7'd0, disp_on}, 8'd0, "R1 deselected on command");
      access(1'b0, 1'b0, 8'hC3, 1'b0, 1'b0, 8'h00, "");
      chk({2'd0, start_line}, 8'd45, "R1 deselected start command");

      // R2: data byte shaped like a command is only stored
      cmd(8'hB8); cmd(8'h40);
      wr(8'h5A); wr(8'h5B);
      cmd(8'h54);
      wr(8'h3F);
      chk({7'd0, disp_on}, 8'd0, "R2 data write not decoded");

      // R8: wrap across column 63 on page 2
      cmd(8'hBA); cmd(8'h7E);
      wr(8'h11); wr(8'h22); wr(8'h33); wr(8'h44);
      cmd(8'h7E);
      rd("R7 dummy read returns reset value");
      rd("R8 read col 62");
      rd("R8 read col 63");
      rd("R8 read col 0 after wrap, same page");

      // R4: page selection
      cmd(8'hBD); cmd(8'h4A);
      wr(8'h6A); wr(8'h6B);
      cmd(8'hBB); cmd(8'h4A);
      wr(8'hC3); wr(8'hC4);
      cmd(8'hBD); cmd(8'h4A);
      // R11 and R1: deselected read
      @(negedge clk);
      rs = 1'b1; rw = 1'b1; cs1_n = 1'b1; cs2_n = 1'b0; cs3 = 1'b1; e = 1'b1;
      @(negedge clk);
      #1 chk({7'd0, oe}, 8'd0, "R11 no drive when deselected");
      @(negedge clk);
      e = 1'b0;
      repeat (5) @(negedge clk);
      rd("R7 stale byte from previous burst");
      rd("R4 page 5 col 10");
      cmd(8'hBB); cmd(8'h4A);
      rd("R7 stale byte after page change");
      rd("R4 page 3 col 10");

      // R10: busy window and dropped access
      @(negedge clk);
      rs = 1'b0; rw = 1'b0; din = 8'h3F; cs1_n = 1'b0; cs2_n = 1'b0; cs3 = 1'b1; e = 1'b1;
      @(negedge clk);
      e = 1'b0;
      @(negedge clk);
      #1 chk({7'd0, busy}, 8'd1, "R10 busy after command");
      din = 8'h3E; e = 1'b1;
      @(negedge clk);
      e = 1'b0;
      @(negedge clk);
      #1 chk({7'd0, busy}, 8'd0, "R10 busy ends after two cycles");
      repeat (4) @(negedge clk);
      chk({7'd0, disp_on}, 8'd1, "R10 command during busy dropped");

      // R6: busy bit in status
      din = 8'h3E; e = 1'b1;
      @(negedge clk);
      e = 1'b0;
      @(negedge clk);
      #1 rw = 1'b1; e = 1'b1;
      #2 chk(dout, 8'hA0, "R6 status shows busy and off");
      @(negedge clk);
      e = 1'b0;
      repeat (5) @(negedge clk);
      cs1_n = 1'b1; cs2_n = 1'b1; cs3 = 1'b0;
      chk({7'd0, disp_on}, 8'd0, "R3 display off again");

      // R9: reset blocks writes, clears registers
      cmd(8'h3F);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk({7'd0, disp_on}, 8'd0, "R9 reset forces off");
      chk({2'd0, start_line}, 8'd0, "R9 reset clears start");
      access(1'b1, 1'b0, 8'h11, 1'b1, 1'b0, 8'h00, "");
      access(1'b0, 1'b0, 8'h3F, 1'b1, 1'b0, 8'h00, "");
      chk({7'd0, disp_on}, 8'd0, "R9 command ignored in reset");
      status(8'h30, "R9 status in second reset");
      rst_n = 1'b1;
      m_page = 3'd0; m_col = 6'd0; m_out = 8'h00;
      rd("R9 output register cleared");
      rd("R9 RAM kept old byte at address 0");

      repeat (4) @(negedge clk);
      summary();
      $finish;
   end

endmodule